// File: doc/BRIEF.md
# Horizontal Drive Soft-Start Generator

This block produces the line-rate horizontal drive pulse, a fixed-width sync strobe at the head of each line and a line-start strobe. It runs from a clock at 432 times the line rate. A line counter divides that clock into lines. An external line reference pulse can realign the counter at any time. A 6-bit shift code moves the rising edge of the drive pulse about a central position. The code is sampled once per line, so a change never splits a pulse.

After any restart, the high time of the drive pulse starts at 2% of the line and climbs to 55%. This soft start protects the output stage. It takes roughly 300 lines. A fault flag (power-on or over-voltage) shuts the drive off and holds it off until an explicit restart command arrives. Standby also turns the drive off, but drive resumes with a fresh ramp as soon as standby is released. The block treats its own reset as a power-on event.

Top module: `hdrive_softstart`

## Requirements
- R1: The line counter runs 0..431 and wraps, so a line lasts 432 clocks. `lineStart` is high exactly while the count is 0. A `lineRef` pulse sampled on an edge makes the count 0 from that edge on.
- R2: `haOut` is high for counts 0 to 31 of every line, which is 32 clocks per line.
- R3: The drive pulse rises at count 49 + floor((15*code + 15)/31). Code 0 gives count 49, code 31 gives 64 and code 63 gives 79. The code is sampled on the edge that starts a line and applies to that whole line.
- R4: Driven line k (k ≥ 1) after a restart has a high time of min(238, 9 + (k-1) - floor((k-1)/4)) clocks. Every fourth step is held. The pulse reaches 238 clocks on line 306 and stays there.
- R5: When `porFlag` or `ovpFlag` is sampled high, `hOut` is low from the next clock on. It stays low, even after the flag drops, until `restartCmd` is sampled while both flags are low. A fresh ramp then starts.
- R6: After reset the drive is halted, as after a power-on fault, until a restart command.
- R7: While `standby` is high, `hOut` is low from the clock after it is sampled. Releasing standby starts a fresh ramp without any command.
- R8: A `restartCmd` that arrives while the drive is running or in standby has no effect on the pulse train.
- R9: Drive resumes only at the first line boundary after a restart, with a full-length first pulse of 9 clocks.
- R10: A `restartCmd` sampled while either fault flag is still high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at 432 times the line rate |
| rstN | input | 1 | Asynchronous active-low reset |
| lineRef | input | 1 | Line phase reference pulse, restarts the line count |
| shiftCode | input | 6 | Horizontal shift code, 31 is centre |
| standby | input | 1 | Standby request, level sensitive |
| porFlag | input | 1 | Power-on fault flag |
| ovpFlag | input | 1 | Over-voltage fault flag |
| restartCmd | input | 1 | Restart command after a latched fault |
| hOut | output | 1 | Horizontal drive pulse |
| haOut | output | 1 | Sync pulse for the first 32 clocks of each line |
| lineStart | output | 1 | High on count 0 of each line |

## Verification
The assertions check the following on every cycle:
- The counter wraps into a line start, and the sync pulse covers the line start.
- The high time only ever grows by one clock or falls back to 9, and it never leaves 238 except on a restart.
- A kill strobe always blanks the drive on the next cycle.
- The halt state is only left by an accepted restart.

Only the bench scenarios can show the following:
- The exact ramp profile over all 310 lines.
- The edge position for each shift code and the one-line latency of a new code.
- The latching of a fault after its flag clears.
- The ignored restarts, and the difference between the standby and fault exits.

// File: rtl/hdrive_pkg.sv
package hdrive_pkg;

  typedef enum logic [1:0] {
    ST_HALT,
    ST_IDLE,
    ST_RAMP,
    ST_STEADY
  } hdrvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMin;   // reload the minimum high time
    logic stepUp;    // widen the pulse by one clock
    logic gateNext;  // drive enable for the next line
    logic killNow;   // blank the drive at once
  } hdrvCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic wrapEv;    // this edge starts a new line
    logic gated;     // the current line is driven
    logic atMax;     // high time is at its ceiling
  } hdrvStat_t;

endpackage

// File: rtl/hdrive_ctrl.sv
module hdrive_ctrl
  import hdrive_pkg::*;
#(
  parameter int HOLD_EVERY = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      porFlag,
  input  logic      ovpFlag,
  input  logic      standby,
  input  logic      restartCmd,
  input  hdrvStat_t stat,
  output hdrvCtl_t  ctl
);

  localparam int SKIP_W = $clog2(HOLD_EVERY + 1);

  hdrvState_t state, stateNxt;
  logic [SKIP_W-1:0] skipCnt;
  logic fault;
  logic stepEv;

  assign fault = porFlag || ovpFlag;

  always_comb begin
    stateNxt = state;
    case (state)
      ST_HALT: begin
        if (!fault && restartCmd) stateNxt = standby ? ST_IDLE : ST_RAMP;
      end
      ST_IDLE: begin
        if (fault) stateNxt = ST_HALT;
        else if (!standby) stateNxt = ST_RAMP;
      end
      ST_RAMP, ST_STEADY: begin
        if (fault) stateNxt = ST_HALT;
        else if (standby) stateNxt = ST_IDLE;
        else if (state == ST_RAMP && stat.atMax) stateNxt = ST_STEADY;
      end
      default: stateNxt = ST_HALT;
    endcase
  end

  // a step opportunity: end of a driven line while ramping and not killed
  assign stepEv = stat.wrapEv && (state == ST_RAMP) && stat.gated && !ctl.killNow;

  always_comb begin
    ctl.killNow  = fault || standby;
    ctl.gateNext = (state == ST_RAMP) || (state == ST_STEADY);
    ctl.loadMin  = (stateNxt == ST_RAMP) && ((state == ST_HALT) || (state == ST_IDLE));
    ctl.stepUp   = stepEv && (skipCnt != SKIP_W'(HOLD_EVERY - 1)) && !stat.atMax;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HALT;
      skipCnt <= '0;
    end else begin
      state <= stateNxt;
      if (ctl.loadMin) skipCnt <= '0;
      else if (stepEv) skipCnt <= (skipCnt == SKIP_W'(HOLD_EVERY - 1)) ? '0 : skipCnt + SKIP_W'(1);
    end
  end

  // leaving halt needs an accepted restart
  p_halt_exit_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_HALT && $past(state) == ST_HALT) |-> ($past(restartCmd) && !$past(fault)));

  // while halted the datapath must not be driving
  p_halt_dark_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT) |-> !stat.gated);

endmodule

// File: rtl/hdrive_dp.sv
module hdrive_dp
  import hdrive_pkg::*;
#(
  parameter int LINE_CLKS  = 432,
  parameter int HA_CLKS    = 32,
  parameter int DUTY_MIN   = 9,
  parameter int DUTY_MAX   = 238,
  parameter int SHIFT_W    = 6,
  parameter int SHIFT_SPAN = 15,
  parameter int DRIVE_BASE = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineRef,
  input  logic [SHIFT_W-1:0] shiftCode,
  input  hdrvCtl_t           ctl,
  output hdrvStat_t          stat,
  output logic               hOut,
  output logic               haOut,
  output logic               lineStart
);

  localparam int CNT_W  = $clog2(LINE_CLKS);
  localparam int SHIFT_MID = (1 << (SHIFT_W - 1)) - 1;
  localparam int PROD_W = SHIFT_W + 8;

  logic [CNT_W-1:0]  lineCnt;
  logic [CNT_W-1:0]  widthReg;
  logic [CNT_W-1:0]  startReg;
  logic [CNT_W-1:0]  startCalc;
  logic [CNT_W:0]    endPos;
  logic [PROD_W-1:0] prod;
  logic              gateReg;
  logic              wrapEv;

  assign wrapEv = lineRef || (lineCnt == CNT_W'(LINE_CLKS - 1));

  // linear map of the shift code onto a clock offset around the base position
  always_comb begin
    prod      = PROD_W'(SHIFT_SPAN) * PROD_W'(shiftCode) + PROD_W'(SHIFT_SPAN);
    startCalc = CNT_W'(DRIVE_BASE - SHIFT_SPAN) + CNT_W'(prod / PROD_W'(SHIFT_MID));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineCnt  <= '0;
      widthReg <= CNT_W'(DUTY_MIN);
      startReg <= CNT_W'(DRIVE_BASE);
      gateReg  <= 1'b0;
    end else begin
      lineCnt <= wrapEv ? '0 : lineCnt + CNT_W'(1);
      if (wrapEv) startReg <= startCalc;
      if (ctl.loadMin) widthReg <= CNT_W'(DUTY_MIN);
      else if (ctl.stepUp) widthReg <= widthReg + CNT_W'(1);
      if (ctl.killNow) gateReg <= 1'b0;
      else if (wrapEv) gateReg <= ctl.gateNext;
    end
  end

  assign endPos    = {1'b0, startReg} + {1'b0, widthReg};
  assign hOut      = gateReg && (lineCnt >= startReg) && ({1'b0, lineCnt} < endPos);
  assign haOut     = lineCnt < CNT_W'(HA_CLKS);
  assign lineStart = (lineCnt == '0);

  always_comb begin
    stat.wrapEv = wrapEv;
    stat.gated  = gateReg;
    stat.atMax  = (widthReg == CNT_W'(DUTY_MAX));
  end

  p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rstN)
    (lineCnt == CNT_W'(LINE_CLKS - 1)) |=> lineStart);

  p_ha_head_r2: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |-> haOut);

  p_width_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (widthReg != $past(widthReg)) |->
      ((widthReg == $past(widthReg) + CNT_W'(1)) || (widthReg == CNT_W'(DUTY_MIN))));

  p_width_ceiling_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(widthReg) == CNT_W'(DUTY_MAX) && !$past(ctl.loadMin)) |-> (widthReg == CNT_W'(DUTY_MAX)));

  p_kill_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.killNow |=> !hOut);

endmodule

// File: rtl/hdrive_softstart.sv
module hdrive_softstart
  import hdrive_pkg::*;
#(
  parameter int LINE_CLKS  = 432,
  parameter int HA_CLKS    = 32,
  parameter int DUTY_MIN   = 9,
  parameter int DUTY_MAX   = 238,
  parameter int HOLD_EVERY = 4,
  parameter int SHIFT_W    = 6,
  parameter int SHIFT_SPAN = 15,
  parameter int DRIVE_BASE = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lineRef,
  input  logic [SHIFT_W-1:0] shiftCode,
  input  logic               standby,
  input  logic               porFlag,
  input  logic               ovpFlag,
  input  logic               restartCmd,
  output logic               hOut,
  output logic               haOut,
  output logic               lineStart
);

  hdrvCtl_t  ctl;
  hdrvStat_t stat;

  hdrive_ctrl #(
    .HOLD_EVERY(HOLD_EVERY)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .porFlag    (porFlag),
    .ovpFlag    (ovpFlag),
    .standby    (standby),
    .restartCmd (restartCmd),
    .stat       (stat),
    .ctl        (ctl)
  );

  hdrive_dp #(
    .LINE_CLKS (LINE_CLKS),
    .HA_CLKS   (HA_CLKS),
    .DUTY_MIN  (DUTY_MIN),
    .DUTY_MAX  (DUTY_MAX),
    .SHIFT_W   (SHIFT_W),
    .SHIFT_SPAN(SHIFT_SPAN),
    .DRIVE_BASE(DRIVE_BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .lineRef   (lineRef),
    .shiftCode (shiftCode),
    .ctl       (ctl),
    .stat      (stat),
    .hOut      (hOut),
    .haOut     (haOut),
    .lineStart (lineStart)
  );

endmodule

// File: tb/test_hdrive_softstart.sv
`timescale 1ns/1ps
module test_hdrive_softstart;

  localparam int LINE = 432;
  localparam int HA = 32;
  localparam int WMIN = 9;
  localparam int WMAX = 238;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineRef = 1'b0;
  logic [5:0] shiftCode = 6'd31;
  logic standby = 1'b0;
  logic porFlag = 1'b0;
  logic ovpFlag = 1'b0;
  logic restartCmd = 1'b0;
  logic hOut, haOut, lineStart;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  bit checking = 1'b0;
  string hTag = "R6";

  always #2.5 clk = ~clk;

  hdrive_softstart i_hdrive_softstart (
    .clk(clk), .rstN(rstN), .lineRef(lineRef), .shiftCode(shiftCode),
    .standby(standby), .porFlag(porFlag), .ovpFlag(ovpFlag),
    .restartCmd(restartCmd), .hOut(hOut), .haOut(haOut), .lineStart(lineStart)
  );

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected high time after n step opportunities (R4)
  function automatic int expW(int n);
    int w;
    w = WMIN + n - n / HOLD;
    return (w > WMAX) ? WMAX : w;
  endfunction

  // expected rise position for a shift code (R3)
  function automatic int expStart(int code);
    return 49 + (15 * code + 15) / 31;
  endfunction

  // reference model, from the requirements
  int mLine, mN, mStart;
  bit mGate, mRun, mHalt;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mLine = 0; mN = 0; mStart = 64; mGate = 0; mRun = 0; mHalt = 1;
    end else begin
      automatic bit wrap = lineRef || (mLine == LINE - 1);
      automatic bit kill = porFlag || ovpFlag || standby;
      mLine = wrap ? 0 : mLine + 1;
      if (wrap) mStart = expStart(int'(shiftCode));
      if (wrap && !kill) begin
        if (mGate && mRun) mN++;
        mGate = mRun;
      end
      if (kill) mGate = 0;
      if (porFlag || ovpFlag) begin mHalt = 1; mRun = 0; end
      else if (mHalt) begin
        if (restartCmd) begin mHalt = 0; if (!standby) begin mRun = 1; mN = 0; end end
      end
      else if (standby) mRun = 0;
      else if (!mRun) begin mRun = 1; mN = 0; end
    end
  end

  // per-cycle comparison and line measurement
  int pos = 0, curCnt = 0, curRise = -1, curHa = 0;
  int lastWidth = 0, lastRise = -1, lastLen = 0, lastHa = 0;
  always @(negedge clk) begin
    if (rstN && checking) begin
      automatic int eh = (mGate && mLine >= mStart && mLine < mStart + expW(mN)) ? 1 : 0;
      chk(hTag, int'(hOut), eh);
      chk("R2", int'(haOut), (mLine < HA) ? 1 : 0);
      chk("R1", int'(lineStart), (mLine == 0) ? 1 : 0);
    end
    if (lineStart) begin
      lastWidth = curCnt; lastRise = curRise; lastLen = pos; lastHa = curHa;
      curCnt = 0; curRise = -1; curHa = 0; pos = 0;
    end
    if (hOut) begin
      if (curRise < 0) curRise = pos;
      curCnt++;
    end
    if (haOut) curHa++;
    pos++;
  end

  task automatic waitLines(int k);
    repeat (k) begin
      @(negedge clk);
      while (!lineStart) @(negedge clk);
    end
    #1;
  endtask

  task automatic pulseRestart();
    @(negedge clk) restartCmd = 1'b1;
    @(negedge clk) restartCmd = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R6 reset hOut", int'(hOut), 0);
    chk("R6 reset haOut", int'(haOut), 1);
    chk("R6 reset lineStart", int'(lineStart), 1);
    checking = 1'b1;
    waitLines(3);
    chk("R6 halted without restart", lastWidth, 0);
    chk("R1 line length", lastLen, LINE);
    chk("R2 sync width", lastHa, HA);

    // full ramp with random shift changes
    hTag = "R4";
    pulseRestart();
    waitLines(1);
    for (int k = 1; k <= 310; k++) begin
      waitLines(1);
      chk((k == 1) ? "R9 first pulse" : "R4 ramp width", lastWidth, expW(k - 1));
      if ($urandom_range(0, 3) == 0) shiftCode = 6'($urandom_range(0, 63));
    end

    // shift extremes and one-line latency
    hTag = "R3";
    shiftCode = 6'd0;
    waitLines(2);
    chk("R3 code 0 rise", lastRise, 49);
    repeat (10) @(negedge clk);
    shiftCode = 6'd63;
    waitLines(1);
    chk("R3 mid-line change waits", lastRise, 49);
    waitLines(1);
    chk("R3 code 63 rise", lastRise, 79);
    shiftCode = 6'd31;
    waitLines(2);
    chk("R3 code 31 rise", lastRise, 64);
    chk("R4 steady width", lastWidth, WMAX);

    // restart while running is ignored
    hTag = "R8";
    pulseRestart();
    waitLines(2);
    chk("R8 restart ignored", lastWidth, WMAX);

    // over-voltage latch
    hTag = "R5";
    repeat (70) @(negedge clk);
    #1 chk("R5 pulse before fault", int'(hOut), 1);
    @(negedge clk) ovpFlag = 1'b1;
    @(negedge clk) #1 chk("R5 drive cut", int'(hOut), 0);
    waitLines(1);
    ovpFlag = 1'b0;
    waitLines(2);
    chk("R5 latched after flag drop", lastWidth, 0);
    hTag = "R10";
    @(negedge clk) ovpFlag = 1'b1;
    pulseRestart();
    @(negedge clk) ovpFlag = 1'b0;
    waitLines(2);
    chk("R10 restart under fault ignored", lastWidth, 0);
    hTag = "R5";
    pulseRestart();
    waitLines(2);
    chk("R5 fresh ramp after ovp", lastWidth, WMIN);
    waitLines(1);
    chk("R5 second line after ovp", lastWidth, WMIN + 1);

    // power-on fault
    @(negedge clk) porFlag = 1'b1;
    @(negedge clk) porFlag = 1'b0;
    waitLines(2);
    chk("R5 por halts", lastWidth, 0);
    pulseRestart();
    waitLines(2);
    chk("R5 fresh ramp after por", lastWidth, WMIN);

    // standby
    hTag = "R7";
    @(negedge clk) standby = 1'b1;
    @(negedge clk) #1 chk("R7 standby cuts", int'(hOut), 0);
    pulseRestart();
    waitLines(2);
    chk("R7 off in standby", lastWidth, 0);
    standby = 1'b0;
    waitLines(2);
    chk("R7 ramp without command", lastWidth, WMIN);

    // line reference realignment
    hTag = "R1";
    repeat (100) @(negedge clk);
    lineRef = 1'b1;
    @(negedge clk) lineRef = 1'b0;
    #1 chk("R1 lineRef restarts line", int'(lineStart), 1);

    // random mix checked against the model
    hTag = "R3";
    for (int c = 0; c < 12 * LINE; c++) begin
      @(negedge clk);
      lineRef = ($urandom_range(0, 799) == 0);
      if ($urandom_range(0, 299) == 0) shiftCode = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 1999) == 0) standby = ~standby;
      if ($urandom_range(0, 2999) == 0) restartCmd = 1'b1; else restartCmd = 1'b0;
    end
    @(negedge clk);
    lineRef = 1'b0; restartCmd = 1'b0; standby = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule